// File: doc/BRIEF.md
# Frame-Bounded Stream Increment Kernel

This block sits between two AXI4-Stream links and adds a fixed constant to the 32-bit data word of every beat it passes. All side information travelling with a beat (byte qualifiers, user bits, stream identifier, routing destination and the end-of-frame flag) leaves the block exactly as it arrived. Each beat passes through a single output holding register, which respects downstream backpressure.

Processing is organised in runs. A run spans one frame: it begins when software sets a start request through a 32-bit AXI4-Lite control word, and it ends when the beat carrying the end-of-frame flag has left the output port. Outside a run the input port refuses all data. Software polls the same control word to see whether the block is idle, whether it can take a new start request, and whether a run has finished. The finished flag clears when the word is read. An auto-repeat bit makes the block begin a fresh run on its own as each run finishes, so a stream of frames can be processed without further writes.

Top module: `stream_incr_kernel`

## Requirements
- R1: Each output data word equals the matching input word plus ADDEND (default 5), modulo 2^32, so 0xFFFFFFFB becomes 0x00000000.
- R2: The tkeep, tstrb, tuser (2 bits), tid (5 bits), tdest (6 bits) and tlast fields of each output beat equal those of the matching input beat.
- R3: While m_axis_tvalid is high and m_axis_tready is low, the output beat stays unchanged. No beat is lost, duplicated or reordered.
- R4: s_axis_tready is high only while a run is active, the end-of-frame beat of that run has not yet been taken, and the holding register is empty or draining in the same cycle.
- R5: A run completes in the cycle its end-of-frame beat is accepted at the output. This sets the done flag, which appears in bit 1 of the control word.
- R6: The control word is at byte offset 0x0. Its bits are: bit 0 start request, bit 1 done, bit 2 idle, bit 3 ready, bit 7 auto-repeat. All other bits read 0, and reads from any other offset return 0.
- R7: Writing a 1 to bit 0 requests a run. The request bit clears itself once a run begins. Writing 0 to bit 0 has no effect.
- R8: A read of the control word returns the done flag and then clears it. If a run completes in the same cycle as the read, the flag stays set.
- R9: Idle (bit 2) reads 1 whenever no run is active, including after reset. Ready (bit 3) reads 1 whenever no start request is waiting.
- R10: Auto-repeat (bit 7) can be written and read back. While it is 1, each completing run sets done and a new run begins at once, with no write to bit 0.
- R11: Every AXI4-Lite write and read gets an OKAY (0) response. Writes to bits 1 to 6, to bits 8 to 31, to other offsets, or with wstrb[0] low change nothing.
- R12: A synchronous active-low reset clears the start request, auto-repeat, done and any beat held at the output, so m_axis_tvalid is 0 and the control word reads 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| s_axis_tdata | input | 32 | Input data word |
| s_axis_tkeep | input | 4 | Input byte keep |
| s_axis_tstrb | input | 4 | Input byte strobe |
| s_axis_tuser | input | 2 | Input user bits |
| s_axis_tid | input | 5 | Input stream identifier |
| s_axis_tdest | input | 6 | Input routing destination |
| s_axis_tlast | input | 1 | Input end-of-frame |
| s_axis_tvalid | input | 1 | Input valid |
| s_axis_tready | output | 1 | Input ready |
| m_axis_tdata | output | 32 | Output data word |
| m_axis_tkeep | output | 4 | Output byte keep |
| m_axis_tstrb | output | 4 | Output byte strobe |
| m_axis_tuser | output | 2 | Output user bits |
| m_axis_tid | output | 5 | Output stream identifier |
| m_axis_tdest | output | 6 | Output routing destination |
| m_axis_tlast | output | 1 | Output end-of-frame |
| m_axis_tvalid | output | 1 | Output valid |
| m_axis_tready | input | 1 | Output ready |

## Verification
The hardest case to reach is a run ending while auto-repeat is on. In that case the block must set done and begin a new run in the same cycle, while a control read may be clearing done. The bench sets auto-repeat and start together and streams one frame. It lets the output drain, reads the control word to confirm that done is set and idle is clear, and then streams a second frame with no write to bit 0. Frames of one to six beats are swept under three downstream ready patterns (always ready, alternating, pseudo-random). The data values cross the 32-bit wrap point.

// File: rtl/sik_pkg.sv
package sik_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned USER_W = 2;
    parameter int unsigned ID_W   = 5;
    parameter int unsigned DEST_W = 6;
    localparam int unsigned BYTES_W = DATA_W / 8;

    localparam int unsigned CW_START = 0;
    localparam int unsigned CW_DONE  = 1;
    localparam int unsigned CW_IDLE  = 2;
    localparam int unsigned CW_READY = 3;
    localparam int unsigned CW_AUTO  = 7;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_BUSY  = 2'd1,
        RUN_DRAIN = 2'd2
    } run_state_e;

    typedef struct packed {
        logic [DATA_W-1:0]  data;
        logic [BYTES_W-1:0] keep;
        logic [BYTES_W-1:0] strb;
        logic [USER_W-1:0]  user;
        logic [ID_W-1:0]    id;
        logic [DEST_W-1:0]  dest;
        logic               last;
    } beat_t;
endpackage

// File: rtl/sik_ctrl_regs.sv
module sik_ctrl_regs
    import sik_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic              idle,
    input  logic              start_ack,
    input  logic              run_done,
    output logic              start_pend,
    output logic              auto_en,
    output logic              done_flag
);
    localparam int unsigned WORD_LSB = 2;

    typedef struct packed {
        logic        start;
        logic        auto_rep;
        logic        done;
        logic        bvalid;
        logic        rvalid;
        logic [31:0] rdata;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_fire, rd_fire, wr_hit, rd_hit;
    logic [31:0] ctrl_word;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CW_START] = r_q.start;
        ctrl_word[CW_DONE]  = r_q.done;
        ctrl_word[CW_IDLE]  = idle;
        ctrl_word[CW_READY] = ~r_q.start;
        ctrl_word[CW_AUTO]  = r_q.auto_rep;
    end

    assign awready = awvalid & wvalid & ~r_q.bvalid;
    assign wready  = awready;
    assign wr_fire = awready;
    assign arready = ~r_q.rvalid;
    assign rd_fire = arvalid & arready;
    assign wr_hit  = (awaddr[ADDR_W-1:WORD_LSB] == '0) & wstrb[0];
    assign rd_hit  = (araddr[ADDR_W-1:WORD_LSB] == '0);

    always_comb begin
        r_d = r_q;
        if (start_ack) begin
            r_d.start = 1'b0;
        end
        if (wr_fire && wr_hit) begin
            if (wdata[CW_START]) begin
                r_d.start = 1'b1;
            end
            r_d.auto_rep = wdata[CW_AUTO];
        end
        if (rd_fire && rd_hit) begin
            r_d.done = 1'b0;
        end
        if (run_done) begin
            r_d.done = 1'b1;
        end
        if (wr_fire) begin
            r_d.bvalid = 1'b1;
        end else if (bready) begin
            r_d.bvalid = 1'b0;
        end
        if (rd_fire) begin
            r_d.rvalid = 1'b1;
            r_d.rdata  = rd_hit ? ctrl_word : '0;
        end else if (rready) begin
            r_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bvalid     = r_q.bvalid;
    assign bresp      = 2'b00;
    assign rvalid     = r_q.rvalid;
    assign rdata      = r_q.rdata;
    assign rresp      = 2'b00;
    assign start_pend = r_q.start;
    assign auto_en    = r_q.auto_rep;
    assign done_flag  = r_q.done;
endmodule

// File: rtl/sik_run_ctrl.sv
module sik_run_ctrl
    import sik_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_pend,
    input  logic auto_en,
    input  logic in_last_fire,
    input  logic out_last_fire,
    output logic accept_en,
    output logic start_ack,
    output logic run_done,
    output logic idle
);
    typedef struct packed {
        run_state_e state;
    } fsm_t;

    fsm_t f_q, f_d;

    always_comb begin
        f_d       = f_q;
        start_ack = 1'b0;
        run_done  = 1'b0;
        unique case (f_q.state)
            RUN_IDLE: begin
                if (start_pend) begin
                    f_d.state = RUN_BUSY;
                    start_ack = 1'b1;
                end
            end
            RUN_BUSY: begin
                if (in_last_fire) begin
                    f_d.state = RUN_DRAIN;
                end
            end
            RUN_DRAIN: begin
                if (out_last_fire) begin
                    run_done = 1'b1;
                    if (auto_en || start_pend) begin
                        f_d.state = RUN_BUSY;
                        start_ack = start_pend;
                    end else begin
                        f_d.state = RUN_IDLE;
                    end
                end
            end
            default: f_d.state = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.state <= RUN_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign accept_en = (f_q.state == RUN_BUSY);
    assign idle      = (f_q.state == RUN_IDLE);
endmodule

// File: rtl/sik_stream_stage.sv
module sik_stream_stage
    import sik_pkg::*;
#(
    parameter logic [DATA_W-1:0] ADDEND = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  accept_en,
    input  logic  s_valid,
    output logic  s_ready,
    input  beat_t s_beat,
    output logic  m_valid,
    input  logic  m_ready,
    output beat_t m_beat,
    output logic  in_last_fire,
    output logic  out_last_fire
);
    typedef struct packed {
        logic  valid;
        beat_t beat;
    } hold_t;

    hold_t h_q, h_d;
    logic  s_fire;
    beat_t sum_beat;

    always_comb begin
        sum_beat      = s_beat;
        sum_beat.data = s_beat.data + ADDEND;
    end

    assign s_ready = accept_en & (~h_q.valid | m_ready);
    assign s_fire  = s_valid & s_ready;

    always_comb begin
        h_d = h_q;
        if (s_fire) begin
            h_d.valid = 1'b1;
            h_d.beat  = sum_beat;
        end else if (m_ready) begin
            h_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign m_valid       = h_q.valid;
    assign m_beat        = h_q.beat;
    assign in_last_fire  = s_fire & s_beat.last;
    assign out_last_fire = h_q.valid & m_ready & h_q.beat.last;
endmodule

// File: rtl/stream_incr_kernel.sv
module stream_incr_kernel
    import sik_pkg::*;
#(
    parameter int unsigned       ADDR_W = 4,
    parameter logic [DATA_W-1:0] ADDEND = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   s_axil_awaddr,
    input  logic                s_axil_awvalid,
    output logic                s_axil_awready,
    input  logic [31:0]         s_axil_wdata,
    input  logic [3:0]          s_axil_wstrb,
    input  logic                s_axil_wvalid,
    output logic                s_axil_wready,
    output logic [1:0]          s_axil_bresp,
    output logic                s_axil_bvalid,
    input  logic                s_axil_bready,
    input  logic [ADDR_W-1:0]   s_axil_araddr,
    input  logic                s_axil_arvalid,
    output logic                s_axil_arready,
    output logic [31:0]         s_axil_rdata,
    output logic [1:0]          s_axil_rresp,
    output logic                s_axil_rvalid,
    input  logic                s_axil_rready,
    input  logic [DATA_W-1:0]   s_axis_tdata,
    input  logic [BYTES_W-1:0]  s_axis_tkeep,
    input  logic [BYTES_W-1:0]  s_axis_tstrb,
    input  logic [USER_W-1:0]   s_axis_tuser,
    input  logic [ID_W-1:0]     s_axis_tid,
    input  logic [DEST_W-1:0]   s_axis_tdest,
    input  logic                s_axis_tlast,
    input  logic                s_axis_tvalid,
    output logic                s_axis_tready,
    output logic [DATA_W-1:0]   m_axis_tdata,
    output logic [BYTES_W-1:0]  m_axis_tkeep,
    output logic [BYTES_W-1:0]  m_axis_tstrb,
    output logic [USER_W-1:0]   m_axis_tuser,
    output logic [ID_W-1:0]     m_axis_tid,
    output logic [DEST_W-1:0]   m_axis_tdest,
    output logic                m_axis_tlast,
    output logic                m_axis_tvalid,
    input  logic                m_axis_tready
);
    beat_t in_beat, out_beat;
    logic  start_pend, auto_en, done_flag;
    logic  accept_en, start_ack, run_done, idle_w;
    logic  in_last_fire, out_last_fire;

    assign in_beat = '{data: s_axis_tdata, keep: s_axis_tkeep, strb: s_axis_tstrb,
                       user: s_axis_tuser, id: s_axis_tid, dest: s_axis_tdest,
                       last: s_axis_tlast};

    sik_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr     (s_axil_awaddr),
        .awvalid    (s_axil_awvalid),
        .awready    (s_axil_awready),
        .wdata      (s_axil_wdata),
        .wstrb      (s_axil_wstrb),
        .wvalid     (s_axil_wvalid),
        .wready     (s_axil_wready),
        .bresp      (s_axil_bresp),
        .bvalid     (s_axil_bvalid),
        .bready     (s_axil_bready),
        .araddr     (s_axil_araddr),
        .arvalid    (s_axil_arvalid),
        .arready    (s_axil_arready),
        .rdata      (s_axil_rdata),
        .rresp      (s_axil_rresp),
        .rvalid     (s_axil_rvalid),
        .rready     (s_axil_rready),
        .idle       (idle_w),
        .start_ack  (start_ack),
        .run_done   (run_done),
        .start_pend (start_pend),
        .auto_en    (auto_en),
        .done_flag  (done_flag)
    );

    sik_run_ctrl u_run (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_pend    (start_pend),
        .auto_en       (auto_en),
        .in_last_fire  (in_last_fire),
        .out_last_fire (out_last_fire),
        .accept_en     (accept_en),
        .start_ack     (start_ack),
        .run_done      (run_done),
        .idle          (idle_w)
    );

    sik_stream_stage #(.ADDEND(ADDEND)) u_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_en     (accept_en),
        .s_valid       (s_axis_tvalid),
        .s_ready       (s_axis_tready),
        .s_beat        (in_beat),
        .m_valid       (m_axis_tvalid),
        .m_ready       (m_axis_tready),
        .m_beat        (out_beat),
        .in_last_fire  (in_last_fire),
        .out_last_fire (out_last_fire)
    );

    assign m_axis_tdata = out_beat.data;
    assign m_axis_tkeep = out_beat.keep;
    assign m_axis_tstrb = out_beat.strb;
    assign m_axis_tuser = out_beat.user;
    assign m_axis_tid   = out_beat.id;
    assign m_axis_tdest = out_beat.dest;
    assign m_axis_tlast = out_beat.last;
endmodule

// File: rtl/sik_checker.sv
module sik_checker
    import sik_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              s_axis_tready,
    input logic              m_axis_tvalid,
    input logic              m_axis_tready,
    input logic [DATA_W-1:0] m_axis_tdata,
    input logic              m_axis_tlast,
    input logic [ID_W-1:0]   m_axis_tid,
    input logic              idle_w,
    input logic              done_flag,
    input logic              s_axil_bvalid,
    input logic [1:0]        s_axil_bresp,
    input logic              s_axil_rvalid,
    input logic [1:0]        s_axil_rresp
);
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_axis_tvalid && !m_axis_tready) |=>
            (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast) && $stable(m_axis_tid)));

    assert_ready_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_axis_tready |-> !idle_w);

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_axis_tvalid && m_axis_tready && m_axis_tlast) |=> done_flag);

    assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w |-> !m_axis_tvalid);

    assert_bresp_okay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_axil_bvalid |-> (s_axil_bresp == 2'b00));

    assert_rresp_okay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_axil_rvalid |-> (s_axil_rresp == 2'b00));
endmodule

bind stream_incr_kernel sik_checker u_sik_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_axis_tready (s_axis_tready),
    .m_axis_tvalid (m_axis_tvalid),
    .m_axis_tready (m_axis_tready),
    .m_axis_tdata  (m_axis_tdata),
    .m_axis_tlast  (m_axis_tlast),
    .m_axis_tid    (m_axis_tid),
    .idle_w        (idle_w),
    .done_flag     (done_flag),
    .s_axil_bvalid (s_axil_bvalid),
    .s_axil_bresp  (s_axil_bresp),
    .s_axil_rvalid (s_axil_rvalid),
    .s_axil_rresp  (s_axil_rresp)
);

// File: tb/stream_incr_kernel_bench.sv
module stream_incr_kernel_bench;
    localparam int AW = 4;
    localparam int BW = 54;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [31:0] wdata = '0, rdata;
    logic [3:0]  wstrb = '0;
    logic [1:0]  bresp, rresp;

    logic [31:0] s_data = '0;
    logic [3:0]  s_keep = '0, s_strb = '0;
    logic [1:0]  s_user = '0;
    logic [4:0]  s_id = '0;
    logic [5:0]  s_dest = '0;
    logic        s_last = 0, s_valid = 0, s_ready;
    logic [31:0] m_data;
    logic [3:0]  m_keep, m_strb;
    logic [1:0]  m_user;
    logic [4:0]  m_id;
    logic [5:0]  m_dest;
    logic        m_last, m_valid;
    logic        m_ready = 1'b1;

    stream_incr_kernel #(.ADDR_W(AW)) u_stream_incr_kernel (
        .clk(clk), .rst_n(rst_n),
        .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
        .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
        .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(bready),
        .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
        .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid), .s_axil_rready(rready),
        .s_axis_tdata(s_data), .s_axis_tkeep(s_keep), .s_axis_tstrb(s_strb),
        .s_axis_tuser(s_user), .s_axis_tid(s_id), .s_axis_tdest(s_dest),
        .s_axis_tlast(s_last), .s_axis_tvalid(s_valid), .s_axis_tready(s_ready),
        .m_axis_tdata(m_data), .m_axis_tkeep(m_keep), .m_axis_tstrb(m_strb),
        .m_axis_tuser(m_user), .m_axis_tid(m_id), .m_axis_tdest(m_dest),
        .m_axis_tlast(m_last), .m_axis_tvalid(m_valid), .m_axis_tready(m_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [BW-1:0] exp_q[$];
    int got_cnt = 0;
    int sent_cnt = 0;
    int bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // downstream ready pattern: 0 always, 1 alternating, 2 pseudo-random
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (bp_mode)
            0: m_ready <= 1'b1;
            1: m_ready <= ~m_ready;
            2: m_ready <= lfsr[0] | lfsr[3];
            default: m_ready <= 1'b0;
        endcase
    end

    // output monitor: R1, R2, R3 ordering
    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            logic [BW-1:0] act;
            logic [BW-1:0] exp;
            act = {m_data, m_keep, m_strb, m_user, m_id, m_dest, m_last};
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected beat", 64'(act), 64'(0));
            end else begin
                exp = exp_q.pop_front();
                check(act[BW-1:22] == exp[BW-1:22], "R1", "data", 64'(act[BW-1:22]), 64'(exp[BW-1:22]));
                check(act[21:0] == exp[21:0], "R2", "sideband", 64'(act[21:0]), 64'(exp[21:0]));
            end
            got_cnt++;
        end
    end

    task automatic lite_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(posedge clk); #1;
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        do @(negedge clk); while (!awready);
        @(posedge clk); #1;
        awvalid = 0; wvalid = 0; bready = 1;
        do @(negedge clk); while (!bvalid);
        check(bresp == 2'b00, "R11", "bresp", 64'(bresp), 64'(0));
        @(posedge clk); #1;
        bready = 0;
    endtask

    task automatic lite_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        araddr = a; arvalid = 1;
        do @(negedge clk); while (!arready);
        @(posedge clk); #1;
        arvalid = 0; rready = 1;
        do @(negedge clk); while (!rvalid);
        d = rdata;
        check(rresp == 2'b00, "R11", "rresp", 64'(rresp), 64'(0));
        @(posedge clk); #1;
        rready = 0;
    endtask

    task automatic expect_ctrl(input logic [31:0] exp, input string req);
        logic [31:0] v;
        lite_read(4'h0, v);
        check(v == exp, req, "control word", 64'(v), 64'(exp));
    endtask

    task automatic send_frame(input int f, input int len);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            s_data = 32'hFFFF_FFFA + 32'(f * 7) + 32'(i);
            s_keep = 4'(i + f);
            s_strb = ~4'(i + f);
            s_user = 2'(i);
            s_id   = 5'(f);
            s_dest = 6'(f * 3 + i);
            s_last = (i == len - 1);
            s_valid = 1;
            do begin
                @(negedge clk);
                if (!s_ready) begin
                    @(posedge clk); #1;
                end
            end while (!s_ready);
            exp_q.push_back({s_data + 32'd5, s_keep, s_strb, s_user, s_id, s_dest, s_last});
            sent_cnt++;
        end
        @(posedge clk); #1;
        s_valid = 0; s_last = 0;
    endtask

    task automatic drain();
        int t = 0;
        while ((got_cnt != sent_cnt || m_valid) && t < 500) begin
            @(negedge clk);
            t++;
        end
        check(got_cnt == sent_cnt, "R3", "beats out vs in", 64'(got_cnt), 64'(sent_cnt));
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 64'(0), 64'(1));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(m_valid == 0, "R12", "m_valid after reset", 64'(m_valid), 64'(0));
        expect_ctrl(32'h0000_000C, "R12");
        expect_ctrl(32'h0000_000C, "R9");
        lite_read(4'h4, v);
        check(v == 0, "R6", "other offset", 64'(v), 64'(0));

        // input refused while no run
        @(posedge clk); #1;
        s_valid = 1; s_data = 32'h1234;
        repeat (4) begin
            @(negedge clk);
            check(s_ready == 0, "R4", "ready without run", 64'(s_ready), 64'(0));
        end
        @(posedge clk); #1;
        s_valid = 0;

        // sweep frames, lengths and backpressure
        for (int f = 0; f < 18; f++) begin
            bp_mode = f % 3;
            lite_write(4'h0, 32'h1, 4'hF);
            if (f == 0) expect_ctrl(32'h0000_0008, "R7");
            send_frame(f, f % 6 + 1);
            @(negedge clk);
            check(s_ready == 0, "R4", "ready after last", 64'(s_ready), 64'(0));
            drain();
            expect_ctrl(32'h0000_000E, "R5");
            if (f < 3) expect_ctrl(32'h0000_000C, "R8");
        end
        bp_mode = 0;

        // ignored writes
        lite_write(4'h0, 32'h0, 4'hF);
        expect_ctrl(32'h0000_000C, "R7");
        lite_write(4'h0, 32'hFFFF_FF7E, 4'hF);
        expect_ctrl(32'h0000_000C, "R11");
        lite_write(4'h0, 32'h0000_0081, 4'h0);
        expect_ctrl(32'h0000_000C, "R11");
        lite_write(4'h4, 32'h0000_0081, 4'hF);
        expect_ctrl(32'h0000_000C, "R11");

        // auto-repeat
        lite_write(4'h0, 32'h0000_0081, 4'h1);
        expect_ctrl(32'h0000_0088, "R10");
        send_frame(20, 3);
        drain();
        expect_ctrl(32'h0000_008A, "R10");
        lite_write(4'h0, 32'h0, 4'hF);
        send_frame(21, 2);
        drain();
        check(sent_cnt == got_cnt, "R10", "second run beats", 64'(got_cnt), 64'(sent_cnt));
        expect_ctrl(32'h0000_000E, "R10");

        // reset with a held beat and auto-repeat set
        lite_write(4'h0, 32'h0000_0081, 4'hF);
        bp_mode = 3;
        repeat (2) @(posedge clk);
        @(posedge clk); #1;
        s_data = 32'h55; s_valid = 1; s_last = 0;
        @(posedge clk); #1;
        s_valid = 0;
        @(negedge clk);
        check(m_valid == 1, "R3", "beat held under backpressure", 64'(m_valid), 64'(1));
        rst_n = 0;
        @(posedge clk); #1;
        rst_n = 1;
        exp_q.delete();
        @(negedge clk);
        check(m_valid == 0, "R12", "held beat cleared", 64'(m_valid), 64'(0));
        bp_mode = 0;
        expect_ctrl(32'h0000_000C, "R12");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule